// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks one requester's load-exclusive / store-exclusive semaphore sequences. A load-exclusive that is naturally aligned and targets non-shared memory records a tag: the aligned granule of its address and its access size. The monitor then moves from OPEN to EXCLUSIVE. A later store-exclusive is allowed only when the monitor is still EXCLUSIVE and the store's granule and size equal the tag. The block then raises a write-enable for the store and returns status 0. In every other case the store is suppressed and the status is 1. Any store-exclusive returns the monitor to OPEN, whether or not it succeeds.

The block also has an explicit clear request and an exception-return input. Both drop the tag without touching memory. Requests are sampled on a rising clock edge, and all responses are registered, so they appear one cycle later. The memory, any global monitor and coherence lie outside the block. `store_go` is the permission that the surrounding datapath uses to perform or drop the write.

Top module: `excl_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the monitor enters OPEN. After that edge, `excl_held`, `resp_valid`, `resp_status`, `store_go` and `align_err` are all 0.
- R2: A request with `req_valid`=1 and `req_op`=0 (load-exclusive) that is aligned, has `req_shared`=0 and has `exc_return`=0 sets EXCLUSIVE and records the tag. One cycle later `resp_valid`=1, `resp_status`=0, `store_go`=0, and `excl_held`=1.
- R3: A store-exclusive (`req_op`=1) that arrives while the monitor is EXCLUSIVE succeeds when the conditions below all hold. One cycle later the outputs are `store_go`=1 and `resp_status`=0.
  - The store is aligned.
  - `req_addr >> GRAN_LG2` equals the tagged granule.
  - `req_size` equals the tagged size.
- R4: A store-exclusive that does not meet all the conditions of R3 fails. This includes a store that arrives while the monitor is OPEN. One cycle later the outputs are `store_go`=0 and `resp_status`=1.
- R5: After any store-exclusive, `excl_held` is 0 one cycle later, whether the store succeeded or failed.
- R6: A second load-exclusive replaces the earlier tag. A store that matches only the older tag then fails.
- R7: A load-exclusive with `req_shared`=1 records no tag and leaves the monitor OPEN. Its response is still `resp_valid`=1 with `resp_status`=0.
- R8: A clear request (`req_op`=2) returns the monitor to OPEN. Its response is `resp_valid`=1, `store_go`=0 and `resp_status`=0.
- R9: `exc_return`=1 at a clock edge returns the monitor to OPEN, with or without a request in the same cycle. A store in that same cycle is still judged against the state held before the edge.
- R10: Sizes are encoded on `req_size` as 0 byte, 1 halfword, 2 word and 3 doubleword. A request is misaligned when any of its low `req_size` address bits is 1. A misaligned load-exclusive or store-exclusive gives `align_err`=1 one cycle later, and the monitor ends OPEN.
- R11: A doubleword tag covers the whole 8-byte granule. A doubleword store to the same address succeeds. A word store at address+4 fails, because the sizes differ.
- R12: `req_op`=3 is ignored. One cycle later `resp_valid`=0, and `excl_held` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 clear, 3 ignored |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_shared | input | 1 | Target memory is shared; no tag is set |
| exc_return | input | 1 | Exception return; drops the tag |
| resp_valid | output | 1 | Registered response for a request of the previous cycle |
| resp_status | output | 1 | 1 = store-exclusive failed |
| store_go | output | 1 | Store-exclusive may write memory |
| align_err | output | 1 | Previous exclusive request was misaligned |
| excl_held | output | 1 | Monitor is in EXCLUSIVE state |

## Verification
A wrong tag or a stale state shows at the ports on the first store-exclusive that follows it. That store's response, one cycle after the request, carries the wrong `store_go` and the wrong status. A state that fails to clear is also visible through `excl_held` one cycle after the clear, the exception return or the store. The bench mixes random address, size and operation sequences over a small pool of overlapping granules with directed replace, clear and doubleword cases. This makes the match logic meet near-miss addresses and sizes often.

// File: rtl/exm_pkg.sv
// Shared types for the exclusive access monitor.
// Assumes two-bit operation and size codes, as stated in the brief.
package exm_pkg;
    typedef enum logic [1:0] {
        OP_LDX  = 2'd0,
        OP_STX  = 2'd1,
        OP_CLR  = 2'd2,
        OP_NONE = 2'd3
    } exm_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } exm_size_e;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_EXCL = 1'b1
    } exm_state_e;
endpackage

// File: rtl/exm_align_chk.sv
// Flags a request whose address is not a multiple of its access size.
// Assumes ADDR_W >= 3, so that the doubleword check has three low bits.
module exm_align_chk #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              misaligned
);
    import exm_pkg::*;

    // Look at the low address bits that the size requires to be zero.
    always_comb begin
        case (exm_size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = |addr[1:0];
            default: misaligned = |addr[2:0];
        endcase
    end
endmodule

// File: rtl/exm_match.sv
// Compares a request's granule and size with the stored tag.
// Assumes the granule (2**GRAN_LG2 bytes) is at least one doubleword.
module exm_match #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 3,
    localparam int TAG_W   = ADDR_W - GRAN_LG2
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [TAG_W-1:0]  tag_gran,
    input  logic [1:0]        tag_size,
    output logic              hit
);
    // The request hits when it lands in the tagged granule with the tagged size.
    always_comb begin
        hit = (req_addr[ADDR_W-1:GRAN_LG2] == tag_gran) && (req_size == tag_size);
    end
endmodule

// File: rtl/exm_tag_reg.sv
// Holds the monitor state and the tag that goes with it.
// Assumes set and clr never arrive together; if they do, clr wins.
module exm_tag_reg #(
    parameter int TAG_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clr,
    input  logic [TAG_W-1:0] set_gran,
    input  logic [1:0]       set_size,
    output logic             excl,
    output logic [TAG_W-1:0] tag_gran,
    output logic [1:0]       tag_size
);
    import exm_pkg::*;

    exm_state_e state_q;

    // State update: reset or clear -> OPEN, set -> EXCLUSIVE.
    always_ff @(posedge clk) begin
        if (!rst_n)   state_q <= ST_OPEN;
        else if (clr) state_q <= ST_OPEN;
        else if (set) state_q <= ST_EXCL;
    end

    // The tag is captured on set; it needs no reset, because the state gates it.
    always_ff @(posedge clk) begin
        if (set && !clr) begin
            tag_gran <= set_gran;
            tag_size <= set_size;
        end
    end

    assign excl = (state_q == ST_EXCL);
endmodule

// File: rtl/excl_monitor.sv
// Local exclusive access monitor for one requester.
// A load-exclusive tags a granule and size; a store-exclusive is allowed only on a live match.
// Assumes one request per cycle; every response is registered and appears one cycle later.
module excl_monitor #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_shared,
    input  logic              exc_return,
    output logic              resp_valid,
    output logic              resp_status,
    output logic              store_go,
    output logic              align_err,
    output logic              excl_held
);
    import exm_pkg::*;

    localparam int TAG_W = ADDR_W - GRAN_LG2;

    exm_op_e          op;
    logic             is_ldx, is_stx, is_clr;
    logic             misaligned, hit, excl;
    logic             tag_set, tag_clr, stx_ok;
    logic [TAG_W-1:0] tag_gran;
    logic [1:0]       tag_size;

    // Decode the operation.
    always_comb begin
        op     = exm_op_e'(req_op);
        is_ldx = req_valid && (op == OP_LDX);
        is_stx = req_valid && (op == OP_STX);
        is_clr = req_valid && (op == OP_CLR);
    end

    exm_align_chk #(.ADDR_W(ADDR_W)) align_i (
        .addr       (req_addr),
        .size       (req_size),
        .misaligned (misaligned)
    );

    exm_match #(.ADDR_W(ADDR_W), .GRAN_LG2(GRAN_LG2)) match_i (
        .req_addr (req_addr),
        .req_size (req_size),
        .tag_gran (tag_gran),
        .tag_size (tag_size),
        .hit      (hit)
    );

    // Decide the tag action and whether the store may go ahead.
    always_comb begin
        tag_set = is_ldx && !misaligned && !req_shared && !exc_return;
        tag_clr = exc_return || is_stx || is_clr || (is_ldx && (misaligned || req_shared));
        stx_ok  = is_stx && excl && hit && !misaligned;
    end

    exm_tag_reg #(.TAG_W(TAG_W)) tag_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (tag_set),
        .clr      (tag_clr),
        .set_gran (req_addr[ADDR_W-1:GRAN_LG2]),
        .set_size (req_size),
        .excl     (excl),
        .tag_gran (tag_gran),
        .tag_size (tag_size)
    );

    // Register the response outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_status <= 1'b0;
            store_go    <= 1'b0;
            align_err   <= 1'b0;
        end else begin
            resp_valid  <= is_ldx || is_stx || is_clr;
            resp_status <= is_stx && !stx_ok;
            store_go    <= stx_ok;
            align_err   <= (is_ldx || is_stx) && misaligned;
        end
    end

    assign excl_held = excl;
endmodule

// File: rtl/excl_monitor_chk.sv
// Temporal checks on the exclusive monitor's ports; bound to every excl_monitor.
// Assumes the op and size encodings given in the brief.
module excl_monitor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_shared,
    input logic              exc_return,
    input logic              resp_valid,
    input logic              resp_status,
    input logic              store_go,
    input logic              align_err,
    input logic              excl_held
);
    AST_RESET_OPEN: assert property (@(posedge clk) !rst_n |=> !excl_held && !resp_valid && !store_go); // R1
    AST_GO_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) store_go |-> resp_valid && !resp_status); // R3
    AST_STX_NEEDS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && !excl_held) |=> !store_go && resp_status); // R4
    AST_STX_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1) |=> !excl_held); // R5
    AST_CLR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2) |=> !excl_held && !store_go); // R8
    AST_EXCRET_OPENS: assert property (@(posedge clk) disable iff (!rst_n) exc_return |=> !excl_held); // R9
    AST_SHARED_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_shared) |=> !excl_held); // R7
    AST_ERR_HAS_RESP: assert property (@(posedge clk) disable iff (!rst_n) align_err |-> resp_valid && !excl_held); // R10
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && !exc_return) |=> !resp_valid && excl_held == $past(excl_held)); // R12
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_shared  (req_shared),
    .exc_return  (exc_return),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .store_go    (store_go),
    .align_err   (align_err),
    .excl_held   (excl_held)
);

// File: tb/excl_monitor_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random traffic, against a bench model.
module excl_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd3;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'd0;
    logic              req_shared = 1'b0;
    logic              exc_return = 1'b0;
    logic              resp_valid, resp_status, store_go, align_err, excl_held;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Bench model state.
    bit              m_excl = 1'b0;
    logic [ADDR_W-1:0] m_gran = '0;
    logic [1:0]      m_size = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    excl_monitor #(.ADDR_W(ADDR_W), .GRAN_LG2(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .req_shared(req_shared),
        .exc_return(exc_return), .resp_valid(resp_valid), .resp_status(resp_status),
        .store_go(store_go), .align_err(align_err), .excl_held(excl_held)
    );

    function automatic bit is_mis(logic [ADDR_W-1:0] a, logic [1:0] s);
        return (a & ((32'd1 << s) - 32'd1)) != 0;
    endfunction

    task automatic check(string req, string what, logic [4:0] act, logic [4:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Issue one cycle of stimulus, then compare every output with the model.
    task automatic step(string req, bit v, logic [1:0] op, logic [ADDR_W-1:0] a,
                        logic [1:0] s, bit sh, bit er);
        bit e_rv, e_st, e_go, e_err, mis, n_excl;
        @(negedge clk);
        req_valid = v; req_op = op; req_addr = a; req_size = s;
        req_shared = sh; exc_return = er;
        mis = is_mis(a, s);
        e_rv = 0; e_st = 0; e_go = 0; e_err = 0; n_excl = m_excl;
        if (v) begin
            case (op)
                2'd0: begin
                    e_rv = 1; e_err = mis; n_excl = !mis && !sh;
                    if (n_excl && !er) begin m_gran = a >> 3; m_size = s; end
                end
                2'd1: begin
                    e_rv = 1; e_err = mis;
                    e_go = m_excl && !mis && ((a >> 3) == m_gran) && (s == m_size);
                    e_st = !e_go; n_excl = 0;
                end
                2'd2: begin e_rv = 1; n_excl = 0; end
                default: ;
            endcase
        end
        if (er) n_excl = 0;
        m_excl = n_excl;
        @(negedge clk);
        req_valid = 1'b0; exc_return = 1'b0;
        check(req, "rv,st,go,err,held", {resp_valid, resp_status, store_go, align_err, excl_held},
              {e_rv, e_st, e_go, e_err, m_excl});
    endtask

    function automatic string tag_of(logic [1:0] op, bit er);
        if (er) return "R9";
        case (op)
            2'd0: return "R2";
            2'd1: return "R3/R4";
            2'd2: return "R8";
            default: return "R12";
        endcase
    endfunction

    initial begin
        int seed = 32'h5eed_0017;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        tests++;
        if ({resp_valid, resp_status, store_go, align_err, excl_held} !== 5'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: actual %b expected 00000",
                     {resp_valid, resp_status, store_go, align_err, excl_held});
        end
        @(negedge clk); rst_n = 1'b1;

        step("R4", 1, 2'd1, 32'h100, 2'd2, 0, 0);     // store while OPEN fails
        step("R2", 1, 2'd0, 32'h100, 2'd2, 0, 0);     // tag word
        step("R3", 1, 2'd1, 32'h100, 2'd2, 0, 0);     // match succeeds
        step("R5", 1, 2'd1, 32'h100, 2'd2, 0, 0);     // second store fails, stays OPEN
        step("R2", 1, 2'd0, 32'h100, 2'd2, 0, 0);
        step("R6", 1, 2'd0, 32'h200, 2'd2, 0, 0);     // replace tag
        step("R6", 1, 2'd1, 32'h100, 2'd2, 0, 0);     // old tag fails
        step("R7", 1, 2'd0, 32'h300, 2'd2, 1, 0);     // shared: no tag
        step("R7", 1, 2'd1, 32'h300, 2'd2, 0, 0);
        step("R2", 1, 2'd0, 32'h300, 2'd1, 0, 0);
        step("R8", 1, 2'd2, 32'h0, 2'd0, 0, 0);       // clear
        step("R8", 1, 2'd1, 32'h300, 2'd1, 0, 0);
        step("R2", 1, 2'd0, 32'h400, 2'd0, 0, 0);
        step("R9", 0, 2'd3, 32'h0, 2'd0, 0, 1);       // exception return alone
        step("R9", 1, 2'd1, 32'h400, 2'd0, 0, 0);
        step("R2", 1, 2'd0, 32'h500, 2'd2, 0, 0);
        step("R9", 1, 2'd1, 32'h500, 2'd2, 0, 1);     // store with exc_return: judged on old state
        step("R10", 1, 2'd0, 32'h602, 2'd2, 0, 0);    // misaligned load
        step("R10", 1, 2'd1, 32'h602, 2'd2, 0, 0);
        step("R11", 1, 2'd0, 32'h700, 2'd3, 0, 0);    // doubleword
        step("R11", 1, 2'd1, 32'h704, 2'd2, 0, 0);    // word at +4 fails
        step("R11", 1, 2'd0, 32'h700, 2'd3, 0, 0);
        step("R11", 1, 2'd1, 32'h700, 2'd3, 0, 0);    // doubleword succeeds
        step("R2", 1, 2'd0, 32'h800, 2'd2, 0, 0);
        step("R12", 1, 2'd3, 32'h800, 2'd2, 0, 0);    // ignored op keeps tag
        step("R12", 1, 2'd1, 32'h800, 2'd2, 0, 0);
        step("R10", 1, 2'd0, 32'h801, 2'd1, 0, 0);    // misaligned halfword

        for (int i = 0; i < 600; i++) begin
            logic [ADDR_W-1:0] a;
            logic [1:0] op, s;
            bit sh, er;
            a  = 32'h100 + ($urandom % 4) * 4;
            if ($urandom % 8 == 0) a = a + 1 + ($urandom % 2);
            s  = 2'($urandom % 4);
            op = ($urandom % 2 == 0) ? 2'd0 : (($urandom % 5 == 0) ? 2'($urandom % 4) : 2'd1);
            sh = ($urandom % 8 == 0);
            er = ($urandom % 16 == 0);
            step(tag_of(op, er), ($urandom % 10 != 0), op, a, s, sh, er);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++; tests++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule